// File: doc/BRIEF.md
# Prefetch Candidate Request Queue

This block sits between a prefetch address generator and the memory-side request port of a cache. It holds a bounded list of candidate prefetch lines. Each candidate carries a ready time. The caller reports each demand miss with its address, a current timestamp and two attribute bits. On the same cycle the generator offers up to `NCAND` candidate addresses, each with its own delay. The queue filters this stream: a demand miss cancels a queued prefetch for the same line, duplicates are refused, a full queue gives up its oldest entry, and in serial-squash mode pending work that is not yet ready is withdrawn from the tail.

When the memory side asks for a prefetch, the queue walks from its head, one entry per cycle. It shows each head line on a probe port, and the cache answers in the same cycle whether the line is resident or already outstanding. Lines that hit are discarded. The first clean line is returned, or the walk reports that nothing was issuable. A memory-side request flag shows whether any work is pending. The head ready time is reported after every notification, and six event counters record what happened.

Top module: `pf_cand_queue`

## Requirements
- R1: Every address comparison (miss removal and duplicate check) uses the block address, which is the address with its low log2(`BLK_BYTES`) bits cleared (bits [5:0] with the default 64). Inserted and issued addresses are block aligned.
- R2: A notification with `miss_uncacheable`=1 is ignored, and so is one with `miss_ifetch`=1 while `cfg_data_only`=1: no removal, no squash, no insertion. An instruction-fetch notification with `cfg_data_only`=0 is processed normally.
- R3: A processed notification removes the queued entry whose block matches the miss, keeps the order of the rest, and adds 1 to `cnt_demand`.
- R4: With `cfg_serial_squash`=1, a processed notification removes entries from the tail toward the head while the tail's ready time is greater than or equal to `miss_time`. It stops at the first older entry and adds the number removed to `cnt_squash`. With `cfg_serial_squash`=0 nothing is squashed.
- R5: A candidate whose block is already queued (including one inserted earlier in the same notification) is not inserted, and `cnt_dup` increments.
- R6: An inserted candidate gets ready time `miss_time` + its delay and goes at the tail. Issue order is insertion order, and lower candidate slots are handled first.
- R7: When a candidate is inserted into a queue already holding `DEPTH` entries, the head entry is dropped first and `cnt_evict` increments. The queue never holds more than `DEPTH`.
- R8: An accepted issue request pops the head once per cycle. A popped line with `probe_in_cache` or `probe_in_mshr` set is discarded and adds 1 to `cnt_discard`. The walk ends with a one-cycle `pf_valid` pulse carrying the first clean line, or with a one-cycle `pf_none` pulse if the queue empties first.
- R9: Each `pf_valid` pulse adds 1 to `cnt_issued`.
- R10: `mem_req` is 1 exactly when the queue holds at least one entry. It falls when removal, squash or a draining walk empties the queue.
- R11: One cycle after any notification, `head_time` shows the ready time of the head entry, or 0 if the queue is empty.
- R12: A notification has priority over issue. An issue request in the same cycle as a notification is not accepted, and a walk in progress makes no step during a cycle with a notification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_data_only | input | 1 | Ignore instruction-fetch notifications |
| cfg_serial_squash | input | 1 | Enable tail squash on each notification |
| miss_valid | input | 1 | Demand-miss notification this cycle |
| miss_addr | input | ADDR_W | Miss byte address |
| miss_time | input | TIME_W | Current timestamp |
| miss_uncacheable | input | 1 | Access is uncacheable |
| miss_ifetch | input | 1 | Access is an instruction fetch |
| cand_valid | input | NCAND | Candidate slot valid bits |
| cand_addr | input | NCAND*ADDR_W | Candidate addresses, slot k at [k*ADDR_W +: ADDR_W] |
| cand_delay | input | NCAND*DLY_W | Candidate delays, slot k at [k*DLY_W +: DLY_W] |
| issue_req | input | 1 | Memory side asks for one prefetch |
| walk_busy | output | 1 | An issue walk is in progress |
| probe_valid | output | 1 | Probe address is being looked up |
| probe_addr | output | ADDR_W | Head line presented to the cache |
| probe_in_cache | input | 1 | Probe line is resident (same cycle) |
| probe_in_mshr | input | 1 | Probe line is already outstanding (same cycle) |
| pf_valid | output | 1 | Prefetch issued (one-cycle pulse) |
| pf_addr | output | ADDR_W | Issued block address |
| pf_none | output | 1 | Walk ended with nothing issuable (pulse) |
| mem_req | output | 1 | Memory-side request flag |
| head_time | output | TIME_W | Head ready time after last notification |
| cnt_issued | output | CNT_W | Prefetches issued |
| cnt_dup | output | CNT_W | Candidates refused as duplicates |
| cnt_demand | output | CNT_W | Entries removed by a matching demand miss |
| cnt_evict | output | CNT_W | Head entries dropped on a full insert |
| cnt_squash | output | CNT_W | Entries squashed from the tail |
| cnt_discard | output | CNT_W | Entries discarded at issue by probe hits |

## Verification
The hardest state to reach is a notification that lands in the middle of an issue walk. The walk has to be paused, the queue has to change underneath it, and the walk then has to continue against the new contents. The bench gets there by making the head line hit in the modelled cache, so the walk survives its first step. Exactly on the following cycle it raises a miss that cancels the only remaining entry, and it expects `pf_none` rather than the cancelled line. The squash stop rule is reached by inserting two candidates whose ready times run backwards, so that a young entry sits behind an older tail and must survive.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  // event slots of the counter bank
  localparam int EVT_ISSUE   = 0;
  localparam int EVT_DUP     = 1;
  localparam int EVT_DEMAND  = 2;
  localparam int EVT_EVICT   = 3;
  localparam int EVT_SQUASH  = 4;
  localparam int EVT_DISCARD = 5;
  localparam int NUM_EVT     = 6;
endpackage

// File: rtl/pfq_match.sv
// Parallel block-address compare against the occupied queue slots.
module pfq_match #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int QC_W   = 4
) (
  input  logic [ADDR_W-1:0]       key,
  input  logic [DEPTH*ADDR_W-1:0] lines,
  input  logic [QC_W-1:0]         fill,
  output logic [DEPTH-1:0]        hit
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = (QC_W'(i) < fill) && (lines[i*ADDR_W +: ADDR_W] == key);
  end
endmodule

// File: rtl/pfq_ctr.sv
// One event counter; adds a per-cycle increment, wraps.
module pfq_ctr #(
  parameter int CNT_W = 16,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] val
);
  always_ff @(posedge clk) begin
    if (!rst_n) val <= '0;
    else        val <= val + CNT_W'(inc);
  end
endmodule

// File: rtl/pf_cand_queue.sv
module pf_cand_queue
  import pfq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int DEPTH     = 8,
  parameter int NCAND     = 2,
  parameter int TIME_W    = 16,
  parameter int DLY_W     = 8,
  parameter int CNT_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_data_only,
  input  logic                    cfg_serial_squash,
  input  logic                    miss_valid,
  input  logic [ADDR_W-1:0]       miss_addr,
  input  logic [TIME_W-1:0]       miss_time,
  input  logic                    miss_uncacheable,
  input  logic                    miss_ifetch,
  input  logic [NCAND-1:0]        cand_valid,
  input  logic [NCAND*ADDR_W-1:0] cand_addr,
  input  logic [NCAND*DLY_W-1:0]  cand_delay,
  input  logic                    issue_req,
  output logic                    walk_busy,
  output logic                    probe_valid,
  output logic [ADDR_W-1:0]       probe_addr,
  input  logic                    probe_in_cache,
  input  logic                    probe_in_mshr,
  output logic                    pf_valid,
  output logic [ADDR_W-1:0]       pf_addr,
  output logic                    pf_none,
  output logic                    mem_req,
  output logic [TIME_W-1:0]       head_time,
  output logic [CNT_W-1:0]        cnt_issued,
  output logic [CNT_W-1:0]        cnt_dup,
  output logic [CNT_W-1:0]        cnt_demand,
  output logic [CNT_W-1:0]        cnt_evict,
  output logic [CNT_W-1:0]        cnt_squash,
  output logic [CNT_W-1:0]        cnt_discard
);
  localparam int QC_W  = $clog2(DEPTH + 1);
  localparam int INC_W = $clog2(DEPTH + NCAND + 1);

  // ---- arithmetic helpers ----
  function automatic logic [ADDR_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(BLK_BYTES - 1);
  endfunction

  function automatic logic [TIME_W-1:0] ready_at(input logic [TIME_W-1:0] now,
                                                 input logic [DLY_W-1:0]  dly);
    return now + TIME_W'(dly);
  endfunction

  function automatic logic skip_note(input logic unc, input logic ifet,
                                     input logic data_only);
    return unc | (ifet & data_only);
  endfunction

  // ---- queue state: slots [0 .. q_cnt-1] valid, slot 0 is the head ----
  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic [TIME_W-1:0] q_time [DEPTH];
  logic [QC_W-1:0]   q_cnt;

  logic [DEPTH*ADDR_W-1:0] q_flat;
  for (genvar i = 0; i < DEPTH; i++) begin : g_flat
    assign q_flat[i*ADDR_W +: ADDR_W] = q_addr[i];
  end

  logic [DEPTH-1:0] miss_hit;
  pfq_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .QC_W(QC_W)) u_miss_match (
    .key  (blk_of(miss_addr)),
    .lines(q_flat),
    .fill (q_cnt),
    .hit  (miss_hit)
  );

  // ---- named internal events ----
  logic note_take;   // notification processed (not ignored)
  logic walk_go;     // a walk step happens this cycle
  logic probe_hit;
  logic ev_issue, ev_discard, ev_demand;
  logic [INC_W-1:0] ev_dup_n, ev_evict_n, ev_squash_n;

  assign note_take   = miss_valid & ~skip_note(miss_uncacheable, miss_ifetch, cfg_data_only);
  assign walk_go     = (walk_busy | issue_req) & ~miss_valid;
  assign probe_valid = walk_go && (q_cnt != '0);
  assign probe_addr  = q_addr[0];
  assign probe_hit   = probe_in_cache | probe_in_mshr;

  // ---- next-state computation ----
  logic [ADDR_W-1:0] n_addr [DEPTH];
  logic [TIME_W-1:0] n_time [DEPTH];
  int                n_cnt;
  int                rm_idx, sq_n, dup_n, evict_n;
  logic              stop_sq, is_dup;
  logic [ADDR_W-1:0] c_blk;
  logic              n_busy, n_pfv, n_pfn;

  always_comb begin
    n_addr    = q_addr;
    n_time    = q_time;
    n_cnt     = int'(q_cnt);
    rm_idx    = -1;
    sq_n      = 0;
    dup_n     = 0;
    evict_n   = 0;
    stop_sq   = 1'b0;
    is_dup    = 1'b0;
    c_blk     = '0;
    ev_demand = 1'b0;
    ev_issue  = 1'b0;
    ev_discard = 1'b0;
    n_busy    = walk_busy;
    n_pfv     = 1'b0;
    n_pfn     = 1'b0;

    if (note_take) begin
      // cancel a queued prefetch for the missing line
      for (int i = 0; i < DEPTH; i++)
        if (miss_hit[i] && rm_idx < 0) rm_idx = i;
      if (rm_idx >= 0) begin
        for (int j = 0; j < DEPTH - 1; j++)
          if (j >= rm_idx) begin
            n_addr[j] = n_addr[j+1];
            n_time[j] = n_time[j+1];
          end
        n_cnt     = n_cnt - 1;
        ev_demand = 1'b1;
      end
      // withdraw not-yet-ready work from the tail
      if (cfg_serial_squash) begin
        for (int i = DEPTH - 1; i >= 0; i--)
          if (i < n_cnt && !stop_sq) begin
            if (n_time[i] >= miss_time) begin
              n_cnt = n_cnt - 1;
              sq_n  = sq_n + 1;
            end else begin
              stop_sq = 1'b1;
            end
          end
      end
      // candidates in slot order
      for (int k = 0; k < NCAND; k++)
        if (cand_valid[k]) begin
          c_blk  = blk_of(cand_addr[k*ADDR_W +: ADDR_W]);
          is_dup = 1'b0;
          for (int j = 0; j < DEPTH; j++)
            if (j < n_cnt && n_addr[j] == c_blk) is_dup = 1'b1;
          if (is_dup) begin
            dup_n = dup_n + 1;
          end else begin
            if (n_cnt == DEPTH) begin
              for (int j = 0; j < DEPTH - 1; j++) begin
                n_addr[j] = n_addr[j+1];
                n_time[j] = n_time[j+1];
              end
              n_cnt   = n_cnt - 1;
              evict_n = evict_n + 1;
            end
            for (int j = 0; j < DEPTH; j++)
              if (j == n_cnt) begin
                n_addr[j] = c_blk;
                n_time[j] = ready_at(miss_time, cand_delay[k*DLY_W +: DLY_W]);
              end
            n_cnt = n_cnt + 1;
          end
        end
    end else if (walk_go) begin
      if (q_cnt == '0) begin
        n_pfn  = 1'b1;
        n_busy = 1'b0;
      end else begin
        for (int j = 0; j < DEPTH - 1; j++) begin
          n_addr[j] = n_addr[j+1];
          n_time[j] = n_time[j+1];
        end
        n_cnt = n_cnt - 1;
        if (!probe_hit) begin
          ev_issue = 1'b1;
          n_pfv    = 1'b1;
          n_busy   = 1'b0;
        end else begin
          ev_discard = 1'b1;
          n_pfn      = (n_cnt == 0);
          n_busy     = (n_cnt != 0);
        end
      end
    end
  end

  assign ev_dup_n    = INC_W'(dup_n);
  assign ev_evict_n  = INC_W'(evict_n);
  assign ev_squash_n = INC_W'(sq_n);

  // ---- registers ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        q_addr[i] <= '0;
        q_time[i] <= '0;
      end
      q_cnt     <= '0;
      walk_busy <= 1'b0;
      pf_valid  <= 1'b0;
      pf_none   <= 1'b0;
      pf_addr   <= '0;
      mem_req   <= 1'b0;
      head_time <= '0;
    end else begin
      q_addr    <= n_addr;
      q_time    <= n_time;
      q_cnt     <= QC_W'(n_cnt);
      walk_busy <= n_busy;
      pf_valid  <= n_pfv;
      pf_none   <= n_pfn;
      if (n_pfv) pf_addr <= q_addr[0];
      mem_req   <= (n_cnt != 0);
      if (miss_valid) head_time <= (n_cnt != 0) ? n_time[0] : '0;
    end
  end

  // ---- event counter bank ----
  logic [INC_W-1:0] ev_inc  [NUM_EVT];
  logic [CNT_W-1:0] ctr_val [NUM_EVT];

  assign ev_inc[EVT_ISSUE]   = INC_W'(ev_issue);
  assign ev_inc[EVT_DUP]     = ev_dup_n;
  assign ev_inc[EVT_DEMAND]  = INC_W'(ev_demand);
  assign ev_inc[EVT_EVICT]   = ev_evict_n;
  assign ev_inc[EVT_SQUASH]  = ev_squash_n;
  assign ev_inc[EVT_DISCARD] = INC_W'(ev_discard);

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_ctr
    pfq_ctr #(.CNT_W(CNT_W), .INC_W(INC_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (ev_inc[e]),
      .val  (ctr_val[e])
    );
  end

  assign cnt_issued  = ctr_val[EVT_ISSUE];
  assign cnt_dup     = ctr_val[EVT_DUP];
  assign cnt_demand  = ctr_val[EVT_DEMAND];
  assign cnt_evict   = ctr_val[EVT_EVICT];
  assign cnt_squash  = ctr_val[EVT_SQUASH];
  assign cnt_discard = ctr_val[EVT_DISCARD];
endmodule

// File: rtl/pfq_chk.sv
module pfq_chk #(
  parameter int DEPTH  = 8,
  parameter int QC_W   = 4,
  parameter int TIME_W = 16,
  parameter int INC_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [QC_W-1:0]   q_cnt,
  input logic              mem_req,
  input logic              miss_valid,
  input logic              ev_issue,
  input logic              ev_discard,
  input logic [INC_W-1:0]  ev_evict_n,
  input logic              pf_valid,
  input logic              pf_none,
  input logic [TIME_W-1:0] head_time
);
  // R7: occupancy bound
  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QC_W'(DEPTH));

  // R7: an eviction leaves the queue full
  assert_evict_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_evict_n != '0) |=> (q_cnt == QC_W'(DEPTH)));

  // R10: an empty queue never requests
  assert_idle_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == '0) |-> !mem_req);

  // R8: a walk ends in exactly one way
  assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pf_valid && pf_none));

  // R9: issuing removes exactly one entry
  assert_issue_pops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |=> (q_cnt == $past(q_cnt) - QC_W'(1)));

  // R12: no walk step under a notification
  assert_note_priority_R12: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> !(ev_issue || ev_discard));

  // R11: empty queue reports zero head time
  assert_empty_head_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> (q_cnt != '0 || head_time == '0));
endmodule

bind pf_cand_queue pfq_chk #(
  .DEPTH(DEPTH), .QC_W(QC_W), .TIME_W(TIME_W), .INC_W(INC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .q_cnt     (q_cnt),
  .mem_req   (mem_req),
  .miss_valid(miss_valid),
  .ev_issue  (ev_issue),
  .ev_discard(ev_discard),
  .ev_evict_n(ev_evict_n),
  .pf_valid  (pf_valid),
  .pf_none   (pf_none),
  .head_time (head_time)
);

// File: tb/pf_cand_queue_test.sv
`timescale 1ns/1ps
module pf_cand_queue_test;
  localparam int AW = 32, TW = 16, DW = 8, CW = 16, NC = 2, DEPTH = 8;
  localparam logic [31:0] NOLINE = 32'hFFFF_FFC0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_data_only = 1'b0, cfg_serial_squash = 1'b0;
  logic miss_valid = 1'b0, miss_uncacheable = 1'b0, miss_ifetch = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic [TW-1:0] miss_time = '0;
  logic [NC-1:0] cand_valid = '0;
  logic [NC*AW-1:0] cand_addr = '0;
  logic [NC*DW-1:0] cand_delay = '0;
  logic issue_req = 1'b0;
  logic walk_busy, probe_valid, pf_valid, pf_none, mem_req;
  logic [AW-1:0] probe_addr, pf_addr;
  logic probe_in_cache, probe_in_mshr;
  logic [TW-1:0] head_time;
  logic [CW-1:0] cnt_issued, cnt_dup, cnt_demand, cnt_evict, cnt_squash, cnt_discard;

  logic [31:0] cache_line [2];
  logic [31:0] mshr_line [2];
  assign probe_in_cache = (probe_addr == cache_line[0]) || (probe_addr == cache_line[1]);
  assign probe_in_mshr  = (probe_addr == mshr_line[0])  || (probe_addr == mshr_line[1]);

  always #10 clk = ~clk;

  pf_cand_queue uut (
    .clk(clk), .rst_n(rst_n), .cfg_data_only(cfg_data_only),
    .cfg_serial_squash(cfg_serial_squash), .miss_valid(miss_valid),
    .miss_addr(miss_addr), .miss_time(miss_time),
    .miss_uncacheable(miss_uncacheable), .miss_ifetch(miss_ifetch),
    .cand_valid(cand_valid), .cand_addr(cand_addr), .cand_delay(cand_delay),
    .issue_req(issue_req), .walk_busy(walk_busy), .probe_valid(probe_valid),
    .probe_addr(probe_addr), .probe_in_cache(probe_in_cache),
    .probe_in_mshr(probe_in_mshr), .pf_valid(pf_valid), .pf_addr(pf_addr),
    .pf_none(pf_none), .mem_req(mem_req), .head_time(head_time),
    .cnt_issued(cnt_issued), .cnt_dup(cnt_dup), .cnt_demand(cnt_demand),
    .cnt_evict(cnt_evict), .cnt_squash(cnt_squash), .cnt_discard(cnt_discard)
  );

  int n_checks = 0, n_fail = 0;
  int e_iss = 0, e_dup = 0, e_dem = 0, e_ev = 0, e_sq = 0, e_dis = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_ctrs(input string tag);
    check({tag, " cnt_issued R9"},   32'(cnt_issued),  32'(e_iss));
    check({tag, " cnt_dup R5"},      32'(cnt_dup),     32'(e_dup));
    check({tag, " cnt_demand R3"},   32'(cnt_demand),  32'(e_dem));
    check({tag, " cnt_evict R7"},    32'(cnt_evict),   32'(e_ev));
    check({tag, " cnt_squash R4"},   32'(cnt_squash),  32'(e_sq));
    check({tag, " cnt_discard R8"},  32'(cnt_discard), 32'(e_dis));
  endtask

  task automatic clear_lookup();
    cache_line[0] = NOLINE; cache_line[1] = NOLINE;
    mshr_line[0]  = NOLINE; mshr_line[1]  = NOLINE;
  endtask

  // one notification, held for one clock; outputs valid on return
  task automatic note(input logic [31:0] a, input logic [15:0] t, input logic unc,
                      input logic ifet, input logic [1:0] cv,
                      input logic [31:0] a0, input logic [7:0] d0,
                      input logic [31:0] a1, input logic [7:0] d1);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = a; miss_time = t;
    miss_uncacheable = unc; miss_ifetch = ifet;
    cand_valid = cv; cand_addr = {a1, a0}; cand_delay = {d1, d0};
    @(negedge clk);
    miss_valid = 1'b0; cand_valid = '0; miss_uncacheable = 1'b0; miss_ifetch = 1'b0;
  endtask

  // one issue request; waits for the walk result
  task automatic issue(output logic got_v, output logic [31:0] got_a, output logic got_n);
    @(negedge clk);
    issue_req = 1'b1;
    @(negedge clk);
    issue_req = 1'b0;
    got_v = 1'b0; got_n = 1'b0; got_a = '0;
    for (int w = 0; w < 30; w++) begin
      if (pf_valid || pf_none) begin
        got_v = pf_valid; got_n = pf_none; got_a = pf_addr;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_issue(input string tag, input logic [31:0] exp_a);
    logic v, n; logic [31:0] a;
    issue(v, a, n);
    check({tag, " pf_valid R8"}, 32'(v), 1);
    check({tag, " pf_addr R6"}, a, exp_a);
    e_iss++;
  endtask

  task automatic expect_none(input string tag);
    logic v, n; logic [31:0] a;
    issue(v, a, n);
    check({tag, " pf_none R8"}, {30'd0, v, n}, 32'b01);
    check({tag, " mem_req low R10"}, 32'(mem_req), 0);
  endtask

  task automatic t_reset();
    check("reset mem_req R10", 32'(mem_req), 0);
    check("reset head_time R11", 32'(head_time), 0);
    check_ctrs("reset");
    expect_none("empty issue");
  endtask

  task automatic t_order();
    note(32'h0001_0000, 16'd100, 0, 0, 2'b11, 32'h1040, 8'd5, 32'h1080, 8'd9);
    check("order head_time R11/R6", 32'(head_time), 105);
    check("order mem_req R10", 32'(mem_req), 1);
    expect_issue("order first", 32'h1040);
    expect_issue("order second", 32'h1080);
    expect_none("order drained");
    check_ctrs("order");
  endtask

  task automatic t_align_dup();
    note(32'h0009_0000, 16'd10, 0, 0, 2'b01, 32'h2000, 8'd1, 32'h0, 8'd0);
    note(32'h0009_1000, 16'd20, 0, 0, 2'b11, 32'h2013, 8'd3, 32'h2047, 8'd4);
    e_dup++;
    check("align head_time R11", 32'(head_time), 11);
    check_ctrs("dedupe R1 R5");
    expect_issue("align first R1", 32'h2000);
    expect_issue("align second R1", 32'h2040);
    expect_none("align drained");
  endtask

  task automatic t_demand();
    note(32'h0009_2000, 16'd30, 0, 0, 2'b11, 32'h3000, 8'd2, 32'h3040, 8'd7);
    note(32'h0000_3005, 16'd40, 0, 0, 2'b00, 32'h0, 8'd0, 32'h0, 8'd0);
    e_dem++;
    check("demand head_time R3", 32'(head_time), 37);
    check_ctrs("demand R3");
    expect_issue("demand survivor R3", 32'h3040);
    expect_none("demand drained");
    // removing the only entry lowers the request flag
    note(32'h0009_2000, 16'd50, 0, 0, 2'b01, 32'h3100, 8'd2, 32'h0, 8'd0);
    note(32'h0000_3110, 16'd51, 0, 0, 2'b00, 32'h0, 8'd0, 32'h0, 8'd0);
    e_dem++;
    check("demand empties mem_req R10", 32'(mem_req), 0);
    check("demand empties head_time R11", 32'(head_time), 0);
  endtask

  task automatic t_ignore();
    cfg_data_only = 1'b1;
    note(32'h0009_3000, 16'd60, 0, 0, 2'b01, 32'h4000, 8'd2, 32'h0, 8'd0);
    note(32'h0000_4000, 16'd61, 1, 0, 2'b01, 32'h4100, 8'd2, 32'h0, 8'd0);
    note(32'h0000_4000, 16'd62, 0, 1, 2'b01, 32'h4140, 8'd2, 32'h0, 8'd0);
    check("ignored keep head R2", 32'(head_time), 62);
    check_ctrs("ignore R2");
    expect_issue("ignore only entry R2", 32'h4000);
    expect_none("ignore drained R2");
    cfg_data_only = 1'b0;
    note(32'h0009_3000, 16'd70, 0, 1, 2'b01, 32'h4180, 8'd1, 32'h0, 8'd0);
    check("ifetch accepted R2", 32'(head_time), 71);
    expect_issue("ifetch entry R2", 32'h4180);
    expect_none("ifetch drained");
  endtask

  task automatic t_squash();
    cfg_serial_squash = 1'b1;
    note(32'h0009_4000, 16'd100, 0, 0, 2'b11, 32'h5000, 8'd10, 32'h5040, 8'd50);
    note(32'h0009_4040, 16'd120, 0, 0, 2'b01, 32'h5080, 8'd1, 32'h0, 8'd0);
    e_sq += 1;
    check_ctrs("squash R4");
    expect_issue("squash keeps older R4", 32'h5000);
    expect_issue("squash new tail R4", 32'h5080);
    expect_none("squash drained");
    // tail older than now stops the squash even with a younger entry ahead
    note(32'h0009_4000, 16'd100, 0, 0, 2'b11, 32'h5100, 8'd30, 32'h5140, 8'd5);
    note(32'h0009_4040, 16'd120, 0, 0, 2'b00, 32'h0, 8'd0, 32'h0, 8'd0);
    check_ctrs("squash stop R4");
    check("squash stop head R4", 32'(head_time), 130);
    // mode off: no squash at all
    cfg_serial_squash = 1'b0;
    note(32'h0009_4080, 16'd2, 0, 0, 2'b00, 32'h0, 8'd0, 32'h0, 8'd0);
    check_ctrs("squash off R4");
    expect_issue("squash stop first R4", 32'h5100);
    expect_issue("squash stop second R4", 32'h5140);
    expect_none("squash stop drained");
  endtask

  task automatic t_full();
    for (int k = 0; k < 4; k++)
      note(32'h0009_5000, 16'(200 + k*10), 0, 0, 2'b11,
           32'h7000 + 32'(k*128), 8'd1, 32'h7040 + 32'(k*128), 8'd2);
    check("full head before R7", 32'(head_time), 201);
    note(32'h0009_5000, 16'd300, 0, 0, 2'b01, 32'h7200, 8'd3, 32'h0, 8'd0);
    e_ev++;
    check("full head after evict R7", 32'(head_time), 202);
    check_ctrs("full R7");
    for (int k = 1; k <= 8; k++)
      expect_issue("full order R7", 32'h7000 + 32'(k*64));
    expect_none("full drained");
  endtask

  task automatic t_filter();
    note(32'h0009_6000, 16'd400, 0, 0, 2'b11, 32'h8000, 8'd1, 32'h8040, 8'd2);
    note(32'h0009_6000, 16'd401, 0, 0, 2'b01, 32'h8080, 8'd3, 32'h0, 8'd0);
    cache_line[0] = 32'h8000; mshr_line[0] = 32'h8040;
    expect_issue("filter skips hits R8", 32'h8080);
    e_dis += 2;
    check("filter empty mem_req R10", 32'(mem_req), 0);
    note(32'h0009_6000, 16'd410, 0, 0, 2'b01, 32'h80C0, 8'd1, 32'h0, 8'd0);
    cache_line[1] = 32'h80C0;
    expect_none("filter all resident R8");
    e_dis += 1;
    check_ctrs("filter R8 R9");
    clear_lookup();
  endtask

  task automatic t_priority();
    logic v, n; logic [31:0] a;
    // same-cycle request is refused
    note(32'h0009_7000, 16'd500, 0, 0, 2'b01, 32'h9000, 8'd1, 32'h0, 8'd0);
    @(negedge clk);
    issue_req = 1'b1; miss_valid = 1'b1; miss_addr = 32'h0009_7000; miss_time = 16'd501;
    @(negedge clk);
    issue_req = 1'b0; miss_valid = 1'b0;
    v = 1'b0; n = 1'b0;
    for (int w = 0; w < 4; w++) begin
      v |= pf_valid; n |= pf_none;
      @(negedge clk);
    end
    check("refused request R12", {30'd0, v, n}, 0);
    check("refused keeps entry R12", 32'(mem_req), 1);
    // walk paused by a notification that cancels the last entry
    note(32'h0009_7000, 16'd502, 0, 0, 2'b01, 32'h9040, 8'd1, 32'h0, 8'd0);
    cache_line[0] = 32'h9000;
    @(negedge clk);
    issue_req = 1'b1;
    @(negedge clk);
    issue_req = 1'b0;
    miss_valid = 1'b1; miss_addr = 32'h0000_9050; miss_time = 16'd503;
    check("walk continuing R12", {30'd0, pf_valid, pf_none}, 0);
    @(negedge clk);
    miss_valid = 1'b0;
    check("walk paused R12", {30'd0, pf_valid, pf_none}, 0);
    @(negedge clk);
    check("paused walk sees empty R12", {30'd0, pf_valid, pf_none}, 32'b01);
    e_dis++; e_dem++;
    check_ctrs("priority R12");
    clear_lookup();
  endtask

  int cyc = 0;
  logic done = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    clear_lookup();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_align_dup();
    t_demand();
    t_ignore();
    t_squash();
    t_full();
    t_filter();
    t_priority();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule